// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps time of day and calendar date in packed BCD. A slow oscillator tick (nominally 32.768 kHz, one clock cycle wide) is turned into an exact-average 100 Hz count enable by a fractional accumulator. That enable advances a chain of fields: hundredths of a second, seconds, minutes, 24-hour hours, day of week, date, month, year and a century bit. Month lengths and leap years are handled by the counter itself.

A host sets the time through one write strobe and one data byte per field. Every strobed byte is loaded on the next clock edge. Any write also clears the hundredths and restarts the prescaler, so a newly set time starts on a whole second. A stop flag held in the seconds byte freezes the whole chain. The same flag with a century-enable flag in the hours byte control the rest of the behaviour.

Top module: `bcd_calendar_clock`

## Requirements
- R1: Field index i (0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year) is strobed by `wr_en[i]` with data `wr_data[8*i+7:8*i]`. Every field is packed BCD with range 00-99, 00-59, 00-59, 00-23, 1-7, 01-31, 01-12, 00-99 in index order. The hundredths byte holds tenths in bits 7:4. The seconds byte carries the stop flag in bit 7. The hours byte carries century-enable in bit 7 and the century bit in bit 6.
- R2: After reset the outputs read 00.00 seconds, 00 minutes, 00 hours, day 1, date 01, month 01, year 00, with stop, century-enable and century all 0.
- R3: Any write strobe forces the hundredths to 00 on the next edge, whatever data accompanies it. It also restarts the prescaler, and no count happens in that cycle.
- R4: The prescaler adds TICK_HZ per oscillator tick and wraps at OSC_HZ. The first 100 Hz pulse after a restart comes on oscillator tick ceil(OSC_HZ/TICK_HZ), which is 328 at default parameters. Exactly TICK_HZ pulses occur per OSC_HZ oscillator ticks. `tick_100hz` is one cycle wide.
- R5: Hundredths 99, seconds 59, minutes 59 and hours 23 each wrap to 00 and carry into the next field. For example, 23:59:59.99 becomes 00:00:00.00 and the date advances.
- R6: Day of week advances whenever the date advances, wrapping from 7 to 1.
- R7: April, June, September and November end after date 30. All other months except February end after date 31.
- R8: February ends after 29 when the BCD year is divisible by 4 (year 00 included), else after 28.
- R9: Month 12 wraps to 01 and advances the year; year 99 wraps to 00.
- R10: On a year wrap the century bit toggles when century-enable is 1 and holds when it is 0.
- R11: While the stop flag is 1, no oscillator tick is counted, `tick_100hz` stays 0 and no field changes. The flag is 0 at reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| wr_en | input | 8 | Per-field write strobes, bit i = field i |
| wr_data | input | 64 | Per-field write data, byte i = field i |
| tick_100hz | output | 1 | Count enable of the hundredths field |
| hund_o | output | 8 | Tenths and hundredths, BCD |
| sec_o | output | 8 | Stop flag and seconds |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Century-enable, century bit and hours |
| dow_o | output | 8 | Day of week 1-7 |
| date_o | output | 8 | Date, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year, BCD |

## Verification
The range assertions assume the host only writes legal BCD values, and never a date beyond the length of the month being written. The stimulus writes whole valid dates drawn from the requirement ranges. Every vector sets all fields in one cycle, so no stale date ever meets a shorter month. The calendar instance runs with a small oscillator ratio so that whole seconds elapse in a few hundred cycles. A second instance at default parameters covers the exact fractional rate.

// File: rtl/calclk_pkg.sv
package calclk_pkg;

   localparam int NF      = 8;
   localparam int F_HUND  = 0;
   localparam int F_SEC   = 1;
   localparam int F_MIN   = 2;
   localparam int F_HOUR  = 3;
   localparam int F_DOW   = 4;
   localparam int F_DATE  = 5;
   localparam int F_MON   = 6;
   localparam int F_YEAR  = 7;

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // bits a write may load; hundredths only ever load zero
   function automatic logic [7:0] field_mask(input int i);
      case (i)
         F_HUND:           return 8'h00;
         F_SEC, F_MIN:     return 8'h7F;
         F_HOUR, F_DATE:   return 8'h3F;
         F_DOW:            return 8'h07;
         F_MON:            return 8'h1F;
         default:          return 8'hFF;
      endcase
   endfunction

   function automatic logic [7:0] field_lo(input int i);
      if (i == F_DOW || i == F_DATE || i == F_MON) return 8'h01;
      else                                        return 8'h00;
   endfunction

   function automatic logic [7:0] field_hi(input int i);
      case (i)
         F_SEC, F_MIN: return 8'h59;
         F_HOUR:       return 8'h23;
         F_DOW:        return 8'h07;
         F_DATE:       return 8'h31;
         F_MON:        return 8'h12;
         default:      return 8'h99;
      endcase
   endfunction

   // divisible by 4 in BCD: even tens -> units 0/4/8, odd tens -> units 2/6
   function automatic logic bcd_leap(input logic [7:0] y);
      if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
   endfunction

   function automatic logic [7:0] month_days(input logic [7:0] m, input logic [7:0] y);
      case (m)
         8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/calclk_prescaler.sv
module calclk_prescaler #(
   parameter int OSC_HZ  = 32768,
   parameter int TICK_HZ = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_tick,
   input  logic run,
   input  logic clear,
   output logic tick
);
   localparam int AW = $clog2(OSC_HZ) + 1;
   localparam logic [AW-1:0] STEP = AW'(TICK_HZ);
   localparam logic [AW-1:0] WRAP = AW'(OSC_HZ);
   localparam logic [AW-1:0] THR  = AW'(OSC_HZ - TICK_HZ);

   initial begin
      a_r4_ratio_legal: assert (TICK_HZ > 0 && 2 * TICK_HZ <= OSC_HZ)
         else $error("prescaler needs 0 < 2*TICK_HZ <= OSC_HZ");
   end

   logic [AW-1:0] acc;
   logic          hit;

   assign hit  = (acc >= THR);
   assign tick = osc_tick & run & ~clear & hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               acc <= '0;
      else if (clear)           acc <= '0;
      else if (osc_tick && run) acc <= hit ? (acc + STEP - WRAP) : (acc + STEP);
   end

   a_r4_acc_below_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      acc < WRAP);
   a_r4_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
   a_r11_no_tick_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !tick);

endmodule

// File: rtl/calclk_bcd_field.sv
module calclk_bcd_field #(
   parameter logic [7:0] LO = 8'h00,
   parameter logic [7:0] HI = 8'h99
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       inc,
   input  logic       wr,
   input  logic [7:0] wr_val,
   input  logic [7:0] wrap_at,
   output logic [7:0] value,
   output logic       carry
);
   import calclk_pkg::*;

   initial begin
      a_r1_bounds_order: assert (LO <= HI) else $error("field bounds reversed");
   end

   // packed BCD compares like binary, so >= also recovers from a too-large value
   assign carry = inc & (value >= wrap_at);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     value <= LO;
      else if (wr)    value <= wr_val;
      else if (carry) value <= LO;
      else if (inc)   value <= bcd_inc(value);
   end

   a_r1_bcd_digits: assert property (@(posedge clk) disable iff (!rst_n)
      (value[3:0] <= 4'd9) && (value[7:4] <= 4'd9));
   a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (value >= LO) && (value <= HI));
   a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !wr) |=> $stable(value));
   a_r5_wrap_low: assert property (@(posedge clk) disable iff (!rst_n)
      (carry && !wr) |=> (value == LO));

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
   import calclk_pkg::*;
#(
   parameter int OSC_HZ  = 32768,
   parameter int TICK_HZ = 100
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        osc_tick,
   input  logic [7:0]  wr_en,
   input  logic [63:0] wr_data,
   output logic        tick_100hz,
   output logic [7:0]  hund_o,
   output logic [7:0]  sec_o,
   output logic [7:0]  min_o,
   output logic [7:0]  hour_o,
   output logic [7:0]  dow_o,
   output logic [7:0]  date_o,
   output logic [7:0]  month_o,
   output logic [7:0]  year_o
);
   localparam int DW = NF * 8;

   initial begin
      a_r1_port_width: assert ($bits(wr_data) == DW) else $error("data width");
   end

   logic          any_wr;
   logic          pre_tick;
   logic          stop_q, ceb_q, cb_q;
   logic [NF-1:0] inc, carry, fwr;
   logic [7:0]    val [NF];
   logic [7:0]    lim [NF];
   logic [7:0]    dim;

   assign any_wr = |wr_en;

   calclk_prescaler #(.OSC_HZ(OSC_HZ), .TICK_HZ(TICK_HZ)) u_prescaler (
      .clk      (clk),
      .rst_n    (rst_n),
      .osc_tick (osc_tick),
      .run      (~stop_q),
      .clear    (any_wr),
      .tick     (pre_tick)
   );

   assign tick_100hz = pre_tick;
   assign dim        = month_days(val[F_MON], val[F_YEAR]);

   // carry chain: day of week and date both step on the hour wrap
   always_comb begin
      inc         = '0;
      inc[F_HUND] = pre_tick;
      inc[F_SEC]  = carry[F_HUND];
      inc[F_MIN]  = carry[F_SEC];
      inc[F_HOUR] = carry[F_MIN];
      inc[F_DOW]  = carry[F_HOUR];
      inc[F_DATE] = carry[F_HOUR];
      inc[F_MON]  = carry[F_DATE];
      inc[F_YEAR] = carry[F_MON];
   end

   for (genvar i = 0; i < NF; i++) begin : g_field
      if (i == F_DATE) begin : g_dyn
         assign lim[i] = dim;
      end else begin : g_fix
         assign lim[i] = field_hi(i);
      end
      if (i == F_HUND) begin : g_any
         assign fwr[i] = any_wr;
      end else begin : g_own
         assign fwr[i] = wr_en[i];
      end
      calclk_bcd_field #(.LO(field_lo(i)), .HI(field_hi(i))) u_field (
         .clk     (clk),
         .rst_n   (rst_n),
         .inc     (inc[i]),
         .wr      (fwr[i]),
         .wr_val  (wr_data[8*i +: 8] & field_mask(i)),
         .wrap_at (lim[i]),
         .value   (val[i]),
         .carry   (carry[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_q <= 1'b0;
         ceb_q  <= 1'b0;
         cb_q   <= 1'b0;
      end else begin
         if (wr_en[F_SEC]) stop_q <= wr_data[8*F_SEC + 7];
         if (wr_en[F_HOUR]) begin
            ceb_q <= wr_data[8*F_HOUR + 7];
            cb_q  <= wr_data[8*F_HOUR + 6];
         end else if (carry[F_YEAR] && ceb_q) begin
            cb_q  <= ~cb_q;
         end
      end
   end

   assign hund_o  = val[F_HUND];
   assign sec_o   = {stop_q, val[F_SEC][6:0]};
   assign min_o   = val[F_MIN];
   assign hour_o  = {ceb_q, cb_q, val[F_HOUR][5:0]};
   assign dow_o   = val[F_DOW];
   assign date_o  = val[F_DATE];
   assign month_o = val[F_MON];
   assign year_o  = val[F_YEAR];

   a_r3_write_clears_hund: assert property (@(posedge clk) disable iff (!rst_n)
      any_wr |=> (hund_o == 8'h00));
   a_r11_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_q && !any_wr) |=> $stable({hund_o, min_o, hour_o, dow_o, date_o, month_o, year_o}));
   a_r10_century_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (carry[F_YEAR] && !ceb_q && !wr_en[F_HOUR]) |=> $stable(cb_q));
   a_r10_century_flips: assert property (@(posedge clk) disable iff (!rst_n)
      (carry[F_YEAR] && ceb_q && !wr_en[F_HOUR]) |=> (cb_q != $past(cb_q)));
   a_r6_dow_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      (carry[F_DOW] && !wr_en[F_DOW]) |=> (dow_o == 8'h01));
   a_r8_date_fits_month: assert property (@(posedge clk) disable iff (!rst_n)
      (inc[F_DATE] && !any_wr) |=> (date_o <= dim));

endmodule

// File: tb/bcd_calendar_clock_bench.sv
module bcd_calendar_clock_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        osc = 1'b0;
   logic        osc_d = 1'b0;
   logic [7:0]  wr_en = '0;
   logic [63:0] wr_data = '0;
   logic        tick, tick_d;
   logic [7:0]  hund, sec, mnt, hour, dow, date, mon, year;
   logic [7:0]  hund_d, sec_d, min_d, hour_d, dow_d, date_d, mon_d, year_d;

   int checks = 0;
   int fails  = 0;
   int ticks_main = 0;
   int pulses_d = 0;
   int ticks_d = 0;
   int first_d = 0;
   bit done = 0;

   always #10 clk = ~clk;

   // calendar instance: 4 oscillator ticks per hundredth, 400 per second
   bcd_calendar_clock #(.OSC_HZ(400), .TICK_HZ(100)) u_bcd_calendar_clock (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc), .wr_en(wr_en), .wr_data(wr_data),
      .tick_100hz(tick), .hund_o(hund), .sec_o(sec), .min_o(mnt), .hour_o(hour),
      .dow_o(dow), .date_o(date), .month_o(mon), .year_o(year));

   // default-rate instance for the fractional prescaler
   bcd_calendar_clock u_bcd_calendar_clock_dflt (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_d), .wr_en(8'h00), .wr_data(64'h0),
      .tick_100hz(tick_d), .hund_o(hund_d), .sec_o(sec_d), .min_o(min_d), .hour_o(hour_d),
      .dow_o(dow_d), .date_o(date_d), .month_o(mon_d), .year_o(year_d));

   always @(posedge clk) begin
      if (tick) ticks_main = ticks_main + 1;
      if (osc_d) begin
         pulses_d = pulses_d + 1;
         if (tick_d) begin
            ticks_d = ticks_d + 1;
            if (first_d == 0) first_d = pulses_d;
         end
      end
   end

   // preset {sec,min,hour,dow,date,mon,yr} -> expected one second later
   localparam int NV = 16;
   localparam logic [111:0] VEC [NV] = '{
      112'h59592303150621_00000004160621,
      112'h30201001090344_31201001090344,
      112'h59591206110807_00001306110807,
      112'h59592307280223_00000001010323,
      112'h59592302280224_00000003290224,
      112'h59592305290224_00000006010324,
      112'h59592301280200_00000002290200,
      112'h59592304280210_00000005010310,
      112'h59592304280212_00000005290212,
      112'h59592303300425_00000004010525,
      112'h59592303300725_00000004310725,
      112'h5959A306311299_0000C007010100,
      112'h59596306311299_00004007010100,
      112'h5959E306311299_00008007010100,
      112'h59592302311245_00000003010146,
      112'h59592301310198_00000002010298
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic pulse(input int n);
      repeat (n) begin
         @(negedge clk) osc = 1'b1;
      end
      @(negedge clk) osc = 1'b0;
   endtask

   task automatic write(input logic [7:0] en, input logic [63:0] d);
      @(negedge clk);
      wr_en = en;
      wr_data = d;
      @(negedge clk);
      wr_en = '0;
   endtask

   function automatic logic [55:0] fields();
      return {sec, mnt, hour, dow, date, mon, year};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: reset state
      check("R2 reset fields", {hund, fields()}, 64'h00_00_00_00_01_01_01_00);
      check("R2 reset tick", {63'h0, tick}, 64'h0);
      check("R2 R11 dflt reset", {hund_d, sec_d, min_d, hour_d, dow_d, date_d, mon_d, year_d},
            64'h00_00_00_00_01_01_01_00);

      // R4: fractional prescaler at default rate
      @(negedge clk) osc_d = 1'b1;
      repeat (32768) @(negedge clk);
      osc_d = 1'b0;
      check("R4 first tick index", 64'(first_d), 64'((32768 + 99) / 100));
      check("R4 ticks per period", 64'(ticks_d), 64'd100);
      check("R4 R5 one second", {48'h0, sec_d, hund_d}, {48'h0, 8'h01, 8'h00});

      // R1 R5 R6 R7 R8 R9 R10: vector walk
      for (int v = 0; v < NV; v++) begin
         logic [55:0] pre, exp;
         pre = VEC[v][111:56];
         exp = VEC[v][55:0];
         write(8'hFE, {pre[7:0], pre[15:8], pre[23:16], pre[31:24],
                       pre[39:32], pre[47:40], pre[55:48], 8'h55});
         pulse(400);
         check($sformatf("R1 R5 R6 R7 R8 R9 R10 vector %0d", v), {8'h00, fields()}, {8'h00, exp});
         check($sformatf("R3 R5 vector %0d hundredths", v), {56'h0, hund}, 64'h0);
      end

      // R3: hundredths write loads zero and restarts the divider
      pulse(6);
      check("R4 tick after 4 pulses", {56'h0, hund}, 64'h01);
      write(8'h01, 64'h55);
      check("R3 hundredths cleared", {hund, fields()}, {8'h00, 56'h00000002010298});
      pulse(3);
      check("R3 divider restarted", {56'h0, hund}, 64'h00);
      pulse(1);
      check("R3 R4 first tick after restart", {56'h0, hund}, 64'h01);

      // R11: stop flag freezes the chain
      write(8'h02, {48'h0, 8'h90, 8'h00});
      ticks_main = 0;
      pulse(800);
      check("R11 frozen fields", {hund, fields()}, {8'h00, 56'h90000002010298});
      check("R11 no ticks while stopped", 64'(ticks_main), 64'd0);
      write(8'h02, {48'h0, 8'h10, 8'h00});
      pulse(400);
      check("R11 runs after clear", {48'h0, sec, hund}, {48'h0, 8'h11, 8'h00});

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #(20 * 190000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule